// File: doc/BRIEF.md
# Colour Subcarrier Phase Oscillator

This block is the numerically controlled oscillator that produces the colour subcarrier phase inside an analogue video encoder. A host programs a 32-bit increment through four byte-wide write lanes. On every cycle in which the pixel clock enable is high, the increment is added to a 32-bit phase accumulator that wraps modulo 2^32. The upper ten accumulator bits leave the block as a registered phase word that drives a sine lookup further down the chroma path.

The increment is the subcarrier-to-pixel-clock frequency ratio scaled by 2^32 and rounded. Both frequencies are counted in multiples of the line rate. For example, 227.5 subcarrier cycles over 1716 pixels per line gives 0x21F07C1F, and 283.7516 over 1728 gives 0x2A098ACB. The byte lanes are staged, so the host can rewrite the increment while the oscillator runs without a partly updated value ever being used. A two-bit mode input selects when the phase is forced back to zero: never, on every second field, on every eighth field, or on every line start.

Top module: `subcarrier_nco`

## Requirements
- R1: After reset, `phase_o` is 0, the active increment is 0 (so enabled steps leave the phase at 0), and the internal field count is 0.
- R2: Byte lane address 0 carries increment bits 7:0, address 1 carries bits 15:8, address 2 carries bits 23:16, and address 3 carries bits 31:24.
- R3: Writes to addresses 0 to 2 only stage data and do not change the active increment. A write to address 3 transfers all four staged bytes to the active increment, and the new value is first used by the step one cycle after the write.
- R4: In a cycle with `pix_en_i` high and no phase reset, the accumulator gains the active increment modulo 2^32. With `pix_en_i` low and no reset, the accumulator holds its value.
- R5: `phase_o` equals accumulator bits 31:22, delayed by one clock.
- R6: Mode 2'b00 never resets the phase, whatever `field_start_i` and `line_start_i` do.
- R7: Every `field_start_i` pulse increments a 3-bit field count, in every mode. In mode 2'b01, a field pulse that arrives while the count is even clears the accumulator.
- R8: In mode 2'b10, a field pulse that arrives while the count is 0 clears the accumulator, which happens once every eight fields.
- R9: In mode 2'b11, every `line_start_i` pulse clears the accumulator. In modes 2'b01 and 2'b10, line pulses have no effect.
- R10: A phase reset takes priority over an enabled step in the same cycle, so the accumulator becomes exactly 0.
- R11: With the increment for 227.5/1716 (0x21F07C1F), 1716 enabled steps from zero leave the accumulator equal to 1716 × 0x21F07C1F mod 2^32.
- R12: With the increment for 283.7516/1728 (0x2A098ACB), 1728 enabled steps from zero leave the accumulator equal to 1728 × 0x2A098ACB mod 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 2 | Byte lane select, 0 = least significant |
| wr_data_i | input | 8 | Byte write data |
| pix_en_i | input | 1 | Pixel clock enable, one accumulator step |
| mode_i | input | 2 | Phase reset mode: 00 never, 01 second field, 10 eighth field, 11 line |
| field_start_i | input | 1 | One-cycle pulse at the start of each field |
| line_start_i | input | 1 | One-cycle pulse at the start of each line |
| phase_o | output | 10 | Registered upper accumulator bits |

## Verification
Several properties are checked on every cycle. The active increment moves only after a write to the most significant lane, and that lane lands in the top byte. The accumulator holds when it is neither stepped nor cleared, and it reads zero after any clear. No clear is ever raised in mode 00 or without a timing pulse. Other behaviour shows only in the bench scenarios, which compare the output against a model running alongside. These scenarios cover the field counting pattern in the two field modes, how staged bytes combine with the top lane, the exact wrapped phase after a full line at both frequency ratios, and a clear arriving together with an enabled step.

// File: rtl/scnco_pkg.sv
package scnco_pkg;
  typedef enum logic [1:0] {
    RST_NEVER  = 2'b00,
    RST_FIELD2 = 2'b01,
    RST_FIELD8 = 2'b10,
    RST_LINE   = 2'b11
  } rst_mode_e;

  localparam int FCNT_W = 3;
endpackage

// File: rtl/scnco_regs.sv
module scnco_regs #(
  parameter int ACC_W  = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = ACC_W / BYTE_W,
  localparam int AW    = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [ACC_W-1:0]  incr_o
);
  localparam logic [AW-1:0] MSB_ADDR = AW'(NB - 1);

  logic [NB-2:0][BYTE_W-1:0] stage_q;
  logic [ACC_W-1:0]          incr_q;
  logic                      commit;

  assign commit = wr_en_i && (wr_addr_i == MSB_ADDR);

  for (genvar g = 0; g < NB - 1; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   stage_q[g] <= '0;
      else if (wr_en_i && (wr_addr_i == AW'(g)))     stage_q[g] <= wr_data_i;
    end
  end

  // top lane write publishes the whole word at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     incr_q <= '0;
    else if (commit) incr_q <= {wr_data_i, stage_q};
  end

  assign incr_o = incr_q;

  assert_incr_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(incr_q));
  assert_msb_lane_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> incr_q[ACC_W-1 -: BYTE_W] == $past(wr_data_i));
endmodule

// File: rtl/scnco_rst_ctrl.sv
module scnco_rst_ctrl
  import scnco_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       field_start_i,
  input  logic       line_start_i,
  output logic       clr_o
);
  logic [FCNT_W-1:0] fcnt_q;
  rst_mode_e         mode;

  assign mode = rst_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            fcnt_q <= '0;
    else if (field_start_i) fcnt_q <= fcnt_q + 1'b1;
  end

  always_comb begin
    unique case (mode)
      RST_NEVER:  clr_o = 1'b0;
      RST_FIELD2: clr_o = field_start_i && !fcnt_q[0];
      RST_FIELD8: clr_o = field_start_i && (fcnt_q == '0);
      RST_LINE:   clr_o = line_start_i;
      default:    clr_o = 1'b0;
    endcase
  end

  assert_never_mode_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |-> !clr_o);
  assert_clr_needs_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> (field_start_i || line_start_i));
endmodule

// File: rtl/scnco_accum.sv
module scnco_accum #(
  parameter int ACC_W = 32,
  parameter int OUT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_en_i,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] incr_i,
  output logic [OUT_W-1:0] phase_o
);
  logic [ACC_W-1:0] acc_q;
  logic [OUT_W-1:0] phase_q;

  // clear wins over a step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clr_i)    acc_q <= '0;
    else if (pix_en_i) acc_q <= acc_q + incr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= acc_q[ACC_W-1 -: OUT_W];
  end

  assign phase_o = phase_q;

  assert_clr_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0));
  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pix_en_i && !clr_i) |=> $stable(acc_q));
endmodule

// File: rtl/subcarrier_nco.sv
module subcarrier_nco #(
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 10,
  parameter int BYTE_W = 8,
  localparam int AW    = $clog2(ACC_W / BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              pix_en_i,
  input  logic [1:0]        mode_i,
  input  logic              field_start_i,
  input  logic              line_start_i,
  output logic [OUT_W-1:0]  phase_o
);
  logic [ACC_W-1:0] incr;
  logic             clr;

  scnco_regs #(.ACC_W(ACC_W), .BYTE_W(BYTE_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .incr_o(incr)
  );

  scnco_rst_ctrl u_rst (
    .clk_i, .rst_ni, .mode_i, .field_start_i, .line_start_i, .clr_o(clr)
  );

  scnco_accum #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_acc (
    .clk_i, .rst_ni, .pix_en_i, .clr_i(clr), .incr_i(incr), .phase_o
  );
endmodule

// File: tb/subcarrier_nco_test.sv
`timescale 1ns/1ps
module subcarrier_nco_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pix_en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       fs = 1'b0;
  logic       ls = 1'b0;
  logic [9:0] phase;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_acc = '0;
  logic [31:0] m_inc = '0;
  logic [23:0] m_stage = '0;
  logic [2:0]  m_fcnt = '0;

  always #4 clk = ~clk;

  subcarrier_nco uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pix_en_i(pix_en), .mode_i(mode),
    .field_start_i(fs), .line_start_i(ls), .phase_o(phase)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a == 2'd3) m_inc = {d, m_stage};
    else m_stage[a*8 +: 8] = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load(input logic [31:0] w);
    for (int i = 0; i < 4; i++) wr(2'(i), w[i*8 +: 8]);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pix_en = 1'b1; m_acc = m_acc + m_inc;
    end
    @(negedge clk); pix_en = 1'b0;
  endtask

  task automatic field_pulse(input logic with_step);
    @(negedge clk); fs = 1'b1; pix_en = with_step;
    if ((mode == 2'b01 && !m_fcnt[0]) || (mode == 2'b10 && m_fcnt == 3'd0)) m_acc = '0;
    else if (with_step) m_acc = m_acc + m_inc;
    m_fcnt = m_fcnt + 3'd1;
    @(negedge clk); fs = 1'b0; pix_en = 1'b0;
  endtask

  task automatic line_pulse(input logic with_step);
    @(negedge clk); ls = 1'b1; pix_en = with_step;
    if (mode == 2'b11) m_acc = '0;
    else if (with_step) m_acc = m_acc + m_inc;
    @(negedge clk); ls = 1'b0; pix_en = 1'b0;
  endtask

  // one idle edge lets the output register catch up
  task automatic chk_phase(input string req);
    @(negedge clk);
    chk(req, 32'(phase), 32'(m_acc[31:22]));
  endtask

  function automatic logic [31:0] ratio_word(input real fsc, input real fpix);
    real r;
    r = fsc / fpix * (2.0 ** 32);
    return 32'(longint'(r));
  endfunction

  task automatic t_reset;
    chk("R1 phase after reset", 32'(phase), 32'h0);
    step(5);
    chk_phase("R1 zero increment");
    mode = 2'b01;
    field_pulse(1'b0);  // count 0 clears
    chk_phase("R1 field count starts at 0");
    mode = 2'b00;
  endtask

  task automatic t_lanes;
    load(32'h0040_0000);  // one output LSB per step
    step(3);
    chk_phase("R2 lane 2 bits");
    chk("R2 three steps", 32'(phase), 32'd3);
    m_acc = m_acc; // keep model
    load(32'h0100_0000);
    step(1);
    chk_phase("R2 lane 3 bits");
  endtask

  task automatic t_staging;
    logic [31:0] old_inc;
    old_inc = m_inc;
    wr(2'd0, 8'hAA); wr(2'd1, 8'hBB); wr(2'd2, 8'h7F);
    chk("R3 model unchanged", m_inc, old_inc);
    step(4);
    chk_phase("R3 staged bytes unused");
    wr(2'd3, 8'h05);
    step(4);
    chk_phase("R3 commit on top lane");
  endtask

  task automatic t_hold;
    step(7);
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk_phase("R4 hold while disabled");
    chk_phase("R5 output steady");
    load(32'hFFC0_0000);
    step(3);
    chk_phase("R4 wrap modulo 2^32");
  endtask

  task automatic t_never;
    mode = 2'b00;
    step(2);
    field_pulse(1'b0); line_pulse(1'b0); field_pulse(1'b0);
    chk_phase("R6 no clear in mode 00");
  endtask

  task automatic t_field2;
    mode = 2'b01;
    for (int i = 0; i < 4; i++) begin
      step(3);
      field_pulse(1'b0);
      chk_phase("R7 every second field");
    end
    step(2);
    line_pulse(1'b0);
    chk_phase("R9 line ignored in mode 01");
  endtask

  task automatic t_field8;
    mode = 2'b10;
    for (int i = 0; i < 10; i++) begin
      step(2);
      field_pulse(1'b0);
      chk_phase("R8 every eighth field");
    end
  endtask

  task automatic t_line;
    mode = 2'b11;
    step(9);
    line_pulse(1'b0);
    chk_phase("R9 line clear");
    chk("R9 phase zero", 32'(phase), 32'h0);
    step(3);
    field_pulse(1'b0);
    chk_phase("R9 field ignored in mode 11");
  endtask

  task automatic t_priority;
    mode = 2'b11;
    step(6);
    line_pulse(1'b1);
    chk_phase("R10 clear beats step");
    chk("R10 exact zero", 32'(phase), 32'h0);
  endtask

  task automatic t_ratio(input string req, input real fsc, input real fpix,
                         input logic [31:0] exp_w, input int n);
    logic [31:0] w;
    w = ratio_word(fsc, fpix);
    chk({req, " word"}, w, exp_w);
    mode = 2'b11;
    load(w);
    line_pulse(1'b0);
    step(n);
    chk({req, " model"}, m_acc, 32'(64'(n) * 64'(exp_w)));
    chk_phase({req, " phase after one line"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_staging();
    t_hold();
    t_never();
    t_field2();
    t_field8();
    t_line();
    t_priority();
    t_ratio("R11", 227.5, 1716.0, 32'h21F07C1F, 1716);
    t_ratio("R12", 283.7516, 1728.0, 32'h2A098ACB, 1728);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule